// File: doc/BRIEF.md
# Time-Shared Radix-2 Butterfly

This block performs the butterfly step of a decimation-in-frequency FFT stage. It takes two complex operands A and B and one complex twiddle W. It returns the rounded sum A+B and the rounded product (A−B)·W. The twiddle is a signed fraction with CW−1 fractional bits. The complex product is formed from three real products. The `SLOTS` parameter sets how many clocks those products share. With `SLOTS`=1 the block has three multipliers and accepts an operand pair on every enabled clock. With `SLOTS`=2 it has two multipliers, and with `SLOTS`=3 it has one. In the shared modes, the spare clocks between enables drive the multiplier work.

Data moves only on clocks where `ce` is high, and there is no back-pressure. The caller spaces `ce` as the chosen `SLOTS` requires. Each enabled clock presents one operand set, and on the same clock the pipeline moves one step. A one-bit marker enters with the operands and leaves with the matching results. The usual use is to flag the first sample of a transform block. Both results keep the scale of the sum of the inputs. Each is then rounded to `OW` bits, with ties going to the even value.

Top module: `dif_butterfly`

## Requirements
- R1: On each enabled clock, `sum_out` carries round((A+B)/2^(IW+1−OW)), computed per component, for the operands presented four enabled clocks earlier, counting the capture clock as the first.
- R2: `dif_out` carries round(((A−B)·W)/2^(CW−1+IW+1−OW)), computed per component, with the same timing as R1. The caller keeps this value within the signed `OW`-bit range.
- R3: Every complex word holds the real part in its upper half and the imaginary part in its lower half. Both halves are signed two's complement.
- R4: When `ce` is low, `sum_out`, `dif_out` and `sync_out` keep their values.
- R5: `sync_out` carries the `sync_in` bit that was presented with the operands whose results are on the outputs. The marker has the same latency as the data.
- R6: While `rst` is high, the marker pipeline is cleared, and `sync_out` is 0 on the clock after `rst` is seen high. The data registers are not cleared.
- R7: When the discarded part of a value is exactly one half, the result rounds to the even neighbour. For example, 2.5 becomes 2, −3.5 becomes −4, and −0.5 becomes 0.
- R8: With `SLOTS`=2 the block uses two multipliers. `ce` must never be high on two consecutive clocks.
- R9: With `SLOTS`=3 the block uses one multiplier. `ce` must be high at most once in any three consecutive clocks.
- R10: With `SLOTS`=1 the block uses three multipliers and accepts a new operand set on every clock while `ce` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the marker pipeline |
| ce | input | 1 | Clock enable; qualifies inputs and advances the pipeline |
| in_a | input | 2*IW | Operand A, {real, imag} |
| in_b | input | 2*IW | Operand B, {real, imag} |
| twiddle | input | 2*CW | Twiddle W, {real, imag}, CW−1 fractional bits |
| sync_in | input | 1 | Marker presented with the operands |
| sum_out | output | 2*OW | Rounded A+B, {real, imag} |
| dif_out | output | 2*OW | Rounded (A−B)·W, {real, imag} |
| sync_out | output | 1 | Marker aligned with the results |

## Verification
The outputs change on the fourth enabled clock edge, counting the edge that captures the operands. Latency is therefore counted in enable edges, not in clocks. This matters in the shared modes, where two or three clocks pass between enable edges. The bench drives each operand set with its own enable pulse and keeps the expected results in a history. Half a period after each enable edge, it compares the outputs with the entry from three enable pulses earlier, including the marker. The hold and reset checks sample across idle clocks with `ce` low, where nothing may move except the reset clearing of the marker.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  localparam int NPROD = 3;

  function automatic int units_for(input int slots);
    if (slots >= 3) return 1;
    else if (slots == 2) return 2;
    else return 3;
  endfunction

  function automatic int phases_for(input int slots);
    int u;
    u = units_for(slots);
    return (NPROD + u - 1) / u;
  endfunction

endpackage

// File: rtl/bfly_round.sv
module bfly_round #(
  parameter int WI = 18,
  parameter int D  = 1,
  parameter int WO = 16
) (
  input  logic signed [WI-1:0] din,
  output logic        [WO-1:0] dout
);

  generate
    if (D == 0) begin : g_pass
      assign dout = WO'(din);
    end else begin : g_rne
      localparam logic signed [WI:0] BIAS = (WI+1)'((1 << (D - 1)) - 1);
      logic signed [WI:0] t;
      // bias is half minus one, plus the lsb that survives: ties go even
      assign t    = (WI+1)'(din) + BIAS + $signed((WI+1)'(din[D]));
      assign dout = WO'(t >>> D);
    end
  endgenerate

endmodule

// File: rtl/bfly_front.sv
module bfly_front #(
  parameter  int IW = 16,
  parameter  int CW = 16,
  localparam int DW = IW + 1,
  localparam int XW = DW + 1,
  localparam int YW = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [2*IW-1:0]      in_a,
  input  logic [2*IW-1:0]      in_b,
  input  logic [2*CW-1:0]      twiddle,
  input  logic                 sync_in,
  output logic signed [DW-1:0] sum_re,
  output logic signed [DW-1:0] sum_im,
  output logic [3*XW-1:0]      x_ops,
  output logic [3*YW-1:0]      y_ops,
  output logic                 sync_q
);

  logic signed [IW-1:0] a_re, a_im, b_re, b_im;
  logic signed [CW-1:0] w_re, w_im;
  logic signed [DW-1:0] d_re, d_im;
  logic signed [CW-1:0] c_re, c_im;

  assign a_re = in_a[2*IW-1:IW];
  assign a_im = in_a[IW-1:0];
  assign b_re = in_b[2*IW-1:IW];
  assign b_im = in_b[IW-1:0];
  assign w_re = twiddle[2*CW-1:CW];
  assign w_im = twiddle[CW-1:0];

  always_ff @(posedge clk) begin
    if (ce) begin
      sum_re <= DW'(a_re) + DW'(b_re);
      sum_im <= DW'(a_im) + DW'(b_im);
      d_re   <= DW'(a_re) - DW'(b_re);
      d_im   <= DW'(a_im) - DW'(b_im);
      c_re   <= w_re;
      c_im   <= w_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     sync_q <= 1'b0;
    else if (ce) sync_q <= sync_in;
  end

  // three-product operands: k0 = c_re*(d_re+d_im), k1 = d_im*(c_re+c_im),
  // k2 = d_re*(c_im-c_re); real = k0-k1, imag = k0+k2
  logic signed [XW-1:0] x0, x1, x2;
  logic signed [YW-1:0] y0, y1, y2;

  always_comb begin
    x0 = XW'(d_re) + XW'(d_im);
    y0 = YW'(c_re);
    x1 = XW'(d_im);
    y1 = YW'(c_re) + YW'(c_im);
    x2 = XW'(d_re);
    y2 = YW'(c_im) - YW'(c_re);
  end

  assign x_ops = {x2, x1, x0};
  assign y_ops = {y2, y1, y0};

  p_sync_capture_r5: assert property (@(posedge clk) disable iff (rst)
    ce |=> sync_q == $past(sync_in));

endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter  int SLOTS = 1,
  parameter  int XW    = 18,
  parameter  int YW    = 17,
  localparam int PW    = XW + YW,
  localparam int RW    = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [3*XW-1:0]      x_ops,
  input  logic [3*YW-1:0]      y_ops,
  output logic signed [RW-1:0] re_q,
  output logic signed [RW-1:0] im_q
);

  localparam int NU  = bfly_pkg::units_for(SLOTS);
  localparam int NP  = bfly_pkg::phases_for(SLOTS);
  localparam int LP  = NP - 1;
  localparam int NS  = NU * NP;
  localparam int PHW = 2;

  // phase counter: cleared by each enable, steps on the idle clocks between
  logic [PHW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)                    ph <= '0;
    else if (ce)                ph <= '0;
    else if (ph != PHW'(LP))    ph <= ph + 1'b1;
  end

  logic signed [XW-1:0] xo [NS];
  logic signed [YW-1:0] yo [NS];

  for (genvar j = 0; j < NS; j++) begin : g_slot
    if (j < bfly_pkg::NPROD) begin : g_live
      assign xo[j] = $signed(x_ops[j*XW +: XW]);
      assign yo[j] = $signed(y_ops[j*YW +: YW]);
    end else begin : g_pad
      assign xo[j] = '0;
      assign yo[j] = '0;
    end
  end

  logic signed [PW-1:0] uprod [NU];

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic signed [XW-1:0] xm;
    logic signed [YW-1:0] ym;
    always_comb begin
      xm = '0;
      ym = '0;
      for (int p = 0; p < NP; p++) begin
        if (ph == PHW'(p)) begin
          xm = xo[p*NU + u];
          ym = yo[p*NU + u];
        end
      end
    end
    assign uprod[u] = PW'(xm) * PW'(ym);
  end

  for (genvar j = 0; j < bfly_pkg::NPROD; j++) begin : g_prod
    localparam int JP = j / NU;
    localparam int JU = j % NU;
    logic signed [PW-1:0] kreg;
    if (JP == LP) begin : g_direct
      always_ff @(posedge clk) begin
        if (ce) kreg <= uprod[JU];
      end
    end else begin : g_held
      logic signed [PW-1:0] kst;
      always_ff @(posedge clk) begin
        if (!ce && ph == PHW'(JP)) kst <= uprod[JU];
        if (ce)                    kreg <= kst;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      re_q <= RW'(g_prod[0].kreg) - RW'(g_prod[1].kreg);
      im_q <= RW'(g_prod[0].kreg) + RW'(g_prod[2].kreg);
    end
  end

  p_phase_range_r8: assert property (@(posedge clk) disable iff (rst)
    ph <= PHW'(LP));

  if (SLOTS >= 2) begin : g_gap2
    p_phase_clear_r8: assert property (@(posedge clk) disable iff (rst)
      ce |=> ph == '0);
    p_ce_gap2_r8: assert property (@(posedge clk) disable iff (rst)
      ce |=> !ce);
  end

  if (SLOTS >= 3) begin : g_gap3
    p_ce_gap3_r9: assert property (@(posedge clk) disable iff (rst)
      ce |=> !ce ##1 !ce);
  end

endmodule

// File: rtl/dif_butterfly.sv
module dif_butterfly #(
  parameter int IW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 16,
  parameter int SLOTS = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic [2*IW-1:0] in_a,
  input  logic [2*IW-1:0] in_b,
  input  logic [2*CW-1:0] twiddle,
  input  logic            sync_in,
  output logic [2*OW-1:0] sum_out,
  output logic [2*OW-1:0] dif_out,
  output logic            sync_out
);

  localparam int DW = IW + 1;
  localparam int XW = DW + 1;
  localparam int YW = CW + 1;
  localparam int RW = XW + YW + 1;
  localparam int SD = DW - OW;
  localparam int PD = CW - 1 + SD;

  // stage 1: operand capture and pre-adds
  logic signed [DW-1:0] s1_re, s1_im;
  logic [3*XW-1:0]      x_ops;
  logic [3*YW-1:0]      y_ops;
  logic                 sy1;

  bfly_front #(.IW(IW), .CW(CW)) u_front (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .in_a    (in_a),
    .in_b    (in_b),
    .twiddle (twiddle),
    .sync_in (sync_in),
    .sum_re  (s1_re),
    .sum_im  (s1_im),
    .x_ops   (x_ops),
    .y_ops   (y_ops),
    .sync_q  (sy1)
  );

  // stages 2 and 3: shared products and recombination
  logic signed [RW-1:0] p3_re, p3_im;

  bfly_cmul #(.SLOTS(SLOTS), .XW(XW), .YW(YW)) u_cmul (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .x_ops (x_ops),
    .y_ops (y_ops),
    .re_q  (p3_re),
    .im_q  (p3_im)
  );

  // sum and marker follow the product through two matching registers
  logic signed [DW-1:0] s2_re, s2_im, s3_re, s3_im;
  logic                 sy2, sy3;

  always_ff @(posedge clk) begin
    if (ce) begin
      s2_re <= s1_re;
      s2_im <= s1_im;
      s3_re <= s2_re;
      s3_im <= s2_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sy2 <= 1'b0;
      sy3 <= 1'b0;
    end else if (ce) begin
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  // stage 4: round to the output width and register
  logic [OW-1:0] r_sre, r_sim, r_pre, r_pim;

  bfly_round #(.WI(DW), .D(SD), .WO(OW)) u_rs_re (.din(s3_re), .dout(r_sre));
  bfly_round #(.WI(DW), .D(SD), .WO(OW)) u_rs_im (.din(s3_im), .dout(r_sim));
  bfly_round #(.WI(RW), .D(PD), .WO(OW)) u_rp_re (.din(p3_re), .dout(r_pre));
  bfly_round #(.WI(RW), .D(PD), .WO(OW)) u_rp_im (.din(p3_im), .dout(r_pim));

  always_ff @(posedge clk) begin
    if (ce) begin
      sum_out <= {r_sre, r_sim};
      dif_out <= {r_pre, r_pim};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     sync_out <= 1'b0;
    else if (ce) sync_out <= sy3;
  end

  p_hold_data_r4: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(sum_out) && $stable(dif_out));

  p_hold_sync_r5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(sync_out));

  p_rst_clears_r6: assert property (@(posedge clk)
    rst |=> !sync_out);

endmodule

// File: tb/dif_butterfly_tb_top.sv
`timescale 1ns/1ps
module dif_butterfly_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [2:0]  ce_v;
  logic [31:0] a_d, b_d, w_d;
  logic        s_d;
  logic [31:0] so [3];
  logic [31:0] dio [3];
  logic        yo [3];

  int n_run = 0, n_fail = 0;
  int cnt [3];
  logic [31:0] hs [3][256];
  logic [31:0] hd [3][256];
  logic        hy [3][256];
  string       ht [3][256];
  bit done = 1'b0;

  dif_butterfly #(.SLOTS(1)) dut_i (
    .clk(clk), .rst(rst), .ce(ce_v[0]), .in_a(a_d), .in_b(b_d), .twiddle(w_d),
    .sync_in(s_d), .sum_out(so[0]), .dif_out(dio[0]), .sync_out(yo[0]));

  dif_butterfly #(.SLOTS(2)) dut2_i (
    .clk(clk), .rst(rst), .ce(ce_v[1]), .in_a(a_d), .in_b(b_d), .twiddle(w_d),
    .sync_in(s_d), .sum_out(so[1]), .dif_out(dio[1]), .sync_out(yo[1]));

  dif_butterfly #(.SLOTS(3)) dut3_i (
    .clk(clk), .rst(rst), .ce(ce_v[2]), .in_a(a_d), .in_b(b_d), .twiddle(w_d),
    .sync_in(s_d), .sum_out(so[2]), .dif_out(dio[2]), .sync_out(yo[2]));

  function automatic logic [15:0] rne16(longint x, int d);
    longint q, r, h;
    q = x >>> d;
    r = x - (q <<< d);
    h = longint'(1) <<< (d - 1);
    if (r > h || (r == h && q[0])) q = q + 1;
    return q[15:0];
  endfunction

  function automatic longint hi(logic [31:0] v);
    return longint'($signed(v[31:16]));
  endfunction

  function automatic longint lo(logic [31:0] v);
    return longint'($signed(v[15:0]));
  endfunction

  function automatic logic [31:0] f_sum(logic [31:0] a, logic [31:0] b);
    return {rne16(hi(a) + hi(b), 1), rne16(lo(a) + lo(b), 1)};
  endfunction

  function automatic logic [31:0] f_dif(logic [31:0] a, logic [31:0] b, logic [31:0] w);
    longint dr, di, cr, ci;
    dr = hi(a) - hi(b);
    di = lo(a) - lo(b);
    cr = hi(w);
    ci = lo(w);
    return {rne16(dr * cr - di * ci, 16), rne16(dr * ci + di * cr, 16)};
  endfunction

  function automatic logic [31:0] rv();
    int v;
    v = int'($urandom_range(16383)) - 8192;
    return {v[15:0], 16'(int'($urandom_range(16383)) - 8192)};
  endfunction

  function automatic logic [31:0] rw();
    return $urandom();
  endfunction

  task automatic check(string tag, logic [31:0] as_, logic [31:0] es,
                       logic [31:0] ad, logic [31:0] ed, logic ay, logic ey);
    n_run++;
    if (as_ !== es || ad !== ed || ay !== ey) begin
      n_fail++;
      $display("FAIL %s: sum %h exp %h, dif %h exp %h, sync %b exp %b",
               tag, as_, es, ad, ed, ay, ey);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // entered at a falling edge; one enable pulse, then the mode's idle clocks
  task automatic step(int m, logic [31:0] a, logic [31:0] b, logic [31:0] w,
                      logic s, string tag);
    int c, k;
    c = cnt[m];
    k = c % 256;
    hs[m][k] = f_sum(a, b);
    hd[m][k] = f_dif(a, b, w);
    hy[m][k] = s;
    ht[m][k] = tag;
    a_d = a; b_d = b; w_d = w; s_d = s;
    ce_v[m] = 1'b1;
    @(negedge clk);
    ce_v[m] = 1'b0;
    if (c >= 3) begin
      k = (c - 3) % 256;
      check(ht[m][k], so[m], hs[m][k], dio[m], hd[m][k], yo[m], hy[m][k]);
    end
    cnt[m] = c + 1;
    repeat (m) @(negedge clk);
  endtask

  task automatic flush(int m, string tag);
    for (int i = 0; i < 3; i++) step(m, 32'h0, 32'h0, 32'h0, 1'b0, tag);
  endtask

  task automatic t_reset_state();
    for (int m = 0; m < 3; m++) check_bit("R6 reset state", yo[m], 1'b0);
  endtask

  task automatic t_full_rate();
    for (int i = 0; i < 12; i++) step(0, rv(), rv(), rw(), 1'b0, "R1 R2 R4 R10");
    flush(0, "R10 flush");
  endtask

  task automatic t_packing();
    step(0, {16'd5, -16'sd7}, 32'h0, {-16'sd32768, 16'd0}, 1'b0, "R3 R7");
    step(0, {16'd0, 16'd100}, {16'd0, -16'sd20}, {16'd0, 16'd32767}, 1'b0, "R3");
    step(0, {16'd300, 16'd0}, {-16'sd300, 16'd0}, {16'd16384, 16'd16384}, 1'b0, "R3");
    flush(0, "R3 flush");
  endtask

  task automatic t_half_even();
    step(2, {16'd1, 16'd3}, 32'h0, {-16'sd32768, 16'd0}, 1'b0, "R7");
    step(2, {-16'sd1, -16'sd3}, 32'h0, {-16'sd32768, 16'd0}, 1'b0, "R7");
    step(2, {16'd5, -16'sd5}, {16'd0, 16'd0}, {16'd0, -16'sd32768}, 1'b0, "R7");
    flush(2, "R7 flush");
  endtask

  task automatic t_two_slot();
    for (int i = 0; i < 10; i++) step(1, rv(), rv(), rw(), 1'b0, "R8");
    flush(1, "R8 flush");
  endtask

  task automatic t_three_slot();
    for (int i = 0; i < 10; i++) step(2, rv(), rv(), rw(), 1'b0, "R9");
    flush(2, "R9 flush");
  endtask

  task automatic t_sync();
    logic [4:0] pat;
    pat = 5'b01101;
    for (int i = 0; i < 5; i++) step(0, rv(), rv(), rw(), pat[i], "R5");
    flush(0, "R5 flush");
    for (int i = 0; i < 5; i++) step(2, rv(), rv(), rw(), pat[i], "R5");
    flush(2, "R5 flush");
  endtask

  task automatic t_hold();
    logic [31:0] s0, d0;
    logic y0;
    step(0, rv(), rv(), rw(), 1'b1, "R4");
    step(0, rv(), rv(), rw(), 1'b1, "R4");
    step(0, rv(), rv(), rw(), 1'b1, "R4");
    step(0, rv(), rv(), rw(), 1'b0, "R4");
    s0 = so[0]; d0 = dio[0]; y0 = yo[0];
    for (int i = 0; i < 5; i++) begin
      a_d = rv(); b_d = rv(); w_d = rw(); s_d = 1'b0;
      @(negedge clk);
    end
    check("R4 hold", so[0], s0, dio[0], d0, yo[0], y0);
    flush(0, "R4 flush");
  endtask

  task automatic t_reset_mid();
    step(1, rv(), rv(), rw(), 1'b1, "R6");
    step(1, rv(), rv(), rw(), 1'b1, "R6");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 3; m++) begin
      check_bit("R6 mid reset", yo[m], 1'b0);
      for (int k = 1; k <= 3; k++)
        if (cnt[m] - k >= 0) hy[m][(cnt[m] - k) % 256] = 1'b0;
    end
    repeat (3) @(negedge clk);
    flush(1, "R6 flush");
    step(1, 32'h0, 32'h0, 32'h0, 1'b0, "R6 flush");
  endtask

  initial begin
    rst = 1'b1;
    ce_v = '0;
    a_d = '0; b_d = '0; w_d = '0; s_d = 1'b0;
    for (int m = 0; m < 3; m++) cnt[m] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_full_rate();
    t_packing();
    t_half_even();
    t_two_slot();
    t_three_slot();
    t_sync();
    t_hold();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule